// File: doc/BRIEF.md
# LED Driver Fault and Power Sequencer

This block is the digital supervisor of a multi-string LED boost driver. It sees the combined enable/dimming input and a set of comparator results already turned into logic levels: supply low, supply recovered and supply high, one short flag and one regulation flag per string, overvoltage on the switch node, overcurrent and excess drop on the output disconnect switch, and two levels of the loop compensation node. From these it drives the boost enable, the per-string sink enables, soft-start mode, compensation float and discharge, the output disconnect switch and a shutdown indication.

The enable input also carries PWM dimming. A short low period only blanks the boost and the sinks while the core stays awake. A low period that reaches `SHDN_LIMIT` clocks (131,072 by default) puts the block into shutdown, and shutdown is the only way to clear latched faults. Supply dips and supply surges are filtered by deglitch counters sized from `CLK_HZ` and `DEGLITCH_US`, so that only a condition that lasts the full window acts.

Top module: `led_fault_seq`

## Requirements
- R1: With enable sampled high and soft start complete, boost_en is 1, sink_en equals the selected string mask and ss_mode is 0. Once enable is sampled low, boost_en is 0, sink_en is 0, comp_float is 1 and shdn_o stays 0 until the shutdown count finishes.
- R2: shdn_o rises at the clock edge on which enable has been sampled low for the SHDN_LIMIT-th consecutive time. It stays high while enable stays low, because the count saturates, and it falls at the first edge that samples enable high.
- R3: Shutdown clears every fault latch. After a shutdown and a new enable, the block goes through soft start and then runs with boost, sinks and disconnect switch on.
- R4: A short flag on any string, selected or not, turns boost_en and sink_en off from the next edge. They stay off through enable-low gaps shorter than SHDN_LIMIT, until a shutdown occurs.
- R5: Overvoltage on the switch node turns off boost, sinks and the disconnect switch from the next edge, and keeps them off until a shutdown occurs.
- R6: Disconnect overcurrent opens the disconnect switch on the next edge and starts a fixed sequence. Boost stops when excess drop is reported. The sinks stop and comp_dis asserts when the compensation node reaches lockout. At the compensation ground level, comp_dis drops and soft-start mode is re-entered with boost and sinks on. The switch stays open and soft-start mode stays on until a shutdown occurs.
- R7: When enabled from the off state, the block is in soft start: ss_mode, boost_en and the mask sinks are on. It leaves soft start only on an edge where every selected string reports regulation. The flags of unselected strings are ignored.
- R8: String i is enabled when i is less than or equal to the value of sel. So sel=0 gives string 0 alone, sel=1 gives strings 0 and 1, sel=2 gives strings 0 to 2, and sel=3 gives all four.
- R9: After reset the block stays off until supply_rise is seen. It turns off only when supply_low is sampled high on DEG_CNT consecutive edges, and a shorter dip has no effect. DEG_CNT is (CLK_HZ/1000)*DEGLITCH_US/1000.
- R10: When supply_high is sampled high on DEG_CNT consecutive edges, boost_en falls at that same edge and the block turns off. Once supply_high clears while enable is high, the block re-enters soft start.
- R11: Fault latches are set-dominant. A short flag present on the same edge as an active shutdown is still latched.
- R12: When enable returns high after a low gap shorter than SHDN_LIMIT, and soft start had already completed, the block goes straight back to full run without soft start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pwm | input | 1 | Enable and PWM dimming input |
| sel | input | SEL_W | String count select (see R8) |
| supply_rise | input | 1 | Supply above undervoltage threshold plus hysteresis |
| supply_low | input | 1 | Supply below undervoltage threshold |
| supply_high | input | 1 | Supply above overvoltage threshold |
| led_short | input | N_STR | Per-string short-detect flags |
| led_ok | input | N_STR | Per-string above-regulation-level flags |
| sw_ov | input | 1 | Switch-node overvoltage |
| dsc_oc | input | 1 | Disconnect-switch overcurrent |
| dsc_drop | input | 1 | Disconnect-switch drop above its threshold |
| comp_lock | input | 1 | Compensation node at lockout level |
| comp_gnd | input | 1 | Compensation node at ground |
| boost_en | output | 1 | Boost converter enable |
| sink_en | output | N_STR | Per-string current sink enable |
| ss_mode | output | 1 | Soft-start mode (reduced limit and sink current) |
| comp_float | output | 1 | Float compensation node |
| comp_dis | output | 1 | Discharge compensation node |
| dsc_on | output | 1 | Output disconnect switch closed |
| shdn_o | output | 1 | Shutdown state |

## Verification
The assertions assume that the comparator flags change only between clock edges and behave like real analog levels. The compensation flags appear only after the overcurrent sequence has reached the matching step, and supply_low and supply_rise are never high together. The stimulus drives every flag a few nanoseconds after an edge and follows the physical order of the overcurrent sequence. It runs the deglitch and shutdown windows at both sides of their boundary, using reduced parameter values so that each window stays short.

// File: rtl/led_fault_seq.sv
module led_fault_seq #(
  parameter int N_STR       = 4,
  parameter int CLK_HZ      = 2_000_000,
  parameter int DEGLITCH_US = 50,
  parameter int SHDN_LIMIT  = 131072
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_pwm,
  input  logic [((N_STR > 1) ? $clog2(N_STR) : 1)-1:0] sel,
  input  logic             supply_rise,
  input  logic             supply_low,
  input  logic             supply_high,
  input  logic [N_STR-1:0] led_short,
  input  logic [N_STR-1:0] led_ok,
  input  logic             sw_ov,
  input  logic             dsc_oc,
  input  logic             dsc_drop,
  input  logic             comp_lock,
  input  logic             comp_gnd,
  output logic             boost_en,
  output logic [N_STR-1:0] sink_en,
  output logic             ss_mode,
  output logic             comp_float,
  output logic             comp_dis,
  output logic             dsc_on,
  output logic             shdn_o
);

  localparam int SEL_W   = (N_STR > 1) ? $clog2(N_STR) : 1;
  localparam int DEG_CNT = (CLK_HZ / 1000) * DEGLITCH_US / 1000;
  localparam int DEG_W   = $clog2(DEG_CNT + 1);
  localparam int SD_W    = $clog2(SHDN_LIMIT + 1);
  localparam logic [DEG_W-1:0] DEG_LAST = DEG_W'(DEG_CNT - 1);
  localparam logic [SD_W-1:0]  SD_TOP   = SD_W'(SHDN_LIMIT);

  typedef enum logic [1:0] {S_OFF, S_SOFT, S_RUN, S_GAP} st_t;
  typedef enum logic [2:0] {OC_NONE, OC_TRIP, OC_BOOST_OFF, OC_DRAIN, OC_DEAD} oc_t;

  st_t             state, state_n;
  oc_t             oc_ph;
  logic            ss_done;
  logic [SD_W-1:0] sd_cnt;
  logic [DEG_W-1:0] uv_cnt, ov_cnt;
  logic            uv_ok, ov_act, pwr_good;
  logic            short_lat, swov_lat, hard;
  logic [N_STR-1:0] sel_mask;
  logic            all_ok, run_on;

  // shutdown timer: saturating, cleared while enable is high
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               sd_cnt <= '0;
    else if (en_pwm)          sd_cnt <= '0;
    else if (sd_cnt != SD_TOP) sd_cnt <= sd_cnt + SD_W'(1);

  assign shdn_o = (sd_cnt == SD_TOP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      uv_cnt <= '0;
      uv_ok  <= 1'b0;
    end else begin
      if (!supply_low)              uv_cnt <= '0;
      else if (uv_cnt != DEG_LAST)  uv_cnt <= uv_cnt + DEG_W'(1);
      if (supply_low && uv_cnt == DEG_LAST) uv_ok <= 1'b0;
      else if (supply_rise)                 uv_ok <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ov_cnt <= '0;
      ov_act <= 1'b0;
    end else begin
      if (!supply_high)             ov_cnt <= '0;
      else if (ov_cnt != DEG_LAST)  ov_cnt <= ov_cnt + DEG_W'(1);
      if (!supply_high)             ov_act <= 1'b0;
      else if (ov_cnt == DEG_LAST)  ov_act <= 1'b1;
    end

  assign pwr_good = uv_ok & ~ov_act;

  for (genvar gi = 0; gi < N_STR; gi++) begin : g_sel
    assign sel_mask[gi] = (SEL_W'(gi) <= sel);
  end

  assign all_ok = &(led_ok | ~sel_mask);

  always_comb begin
    state_n = state;
    if (shdn_o || !pwr_good) state_n = S_OFF;
    else begin
      case (state)
        S_OFF:   if (en_pwm) state_n = S_SOFT;
        S_SOFT:  if (!en_pwm) state_n = S_GAP;
                 else if (all_ok) state_n = S_RUN;
        S_RUN:   if (!en_pwm) state_n = S_GAP;
        S_GAP:   if (en_pwm) state_n = ss_done ? S_RUN : S_SOFT;
        default: state_n = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_OFF;
      ss_done <= 1'b0;
    end else begin
      state   <= state_n;
      ss_done <= (state_n == S_RUN) | (ss_done & (state_n != S_OFF));
    end

  // set-dominant fault latches
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      short_lat <= 1'b0;
      swov_lat  <= 1'b0;
    end else begin
      short_lat <= (|led_short) | (short_lat & ~shdn_o);
      swov_lat  <= sw_ov | (swov_lat & ~shdn_o);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oc_ph <= OC_NONE;
    else if (shdn_o) oc_ph <= dsc_oc ? OC_TRIP : OC_NONE;
    else begin
      case (oc_ph)
        OC_NONE:      if (dsc_oc)    oc_ph <= OC_TRIP;
        OC_TRIP:      if (dsc_drop)  oc_ph <= OC_BOOST_OFF;
        OC_BOOST_OFF: if (comp_lock) oc_ph <= OC_DRAIN;
        OC_DRAIN:     if (comp_gnd)  oc_ph <= OC_DEAD;
        default:      oc_ph <= oc_ph;
      endcase
    end

  assign hard   = short_lat | swov_lat;
  assign run_on = (state == S_SOFT) | (state == S_RUN);

  assign boost_en   = run_on & ~hard & ~ov_act &
                      (oc_ph == OC_NONE || oc_ph == OC_TRIP || oc_ph == OC_DEAD);
  assign sink_en    = (run_on && !hard && oc_ph != OC_DRAIN) ? sel_mask : '0;
  assign ss_mode    = run_on & ~hard & ((state == S_SOFT) | (oc_ph == OC_DEAD));
  assign comp_float = (state == S_GAP) & (oc_ph != OC_DRAIN);
  assign comp_dis   = (oc_ph == OC_DRAIN);
  assign dsc_on     = (state != S_OFF) & (oc_ph == OC_NONE) & ~swov_lat;

  AST_PWM_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pwm |=> (!boost_en && sink_en == '0)); // R1
  AST_EN_NO_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
    en_pwm |=> !shdn_o); // R2
  AST_SHDN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_o && !en_pwm) |=> shdn_o); // R2
  AST_SHORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (|led_short) |=> (!boost_en && sink_en == '0)); // R4
  AST_SWOV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ov |=> (!boost_en && !dsc_on)); // R5
  AST_OC_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_oc |=> !dsc_on); // R6
  AST_OV_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_high && ov_cnt == DEG_LAST) |=> !boost_en); // R10
  AST_SET_DOM: assert property (@(posedge clk) disable iff (!rst_n)
    ((|led_short) && shdn_o) |=> short_lat); // R11

endmodule

// File: tb/led_fault_seq_tb.sv
module led_fault_seq_tb;
  localparam int N   = 4;
  localparam int LIM = 40;
  localparam int DEG = 10;

  logic clk = 0, rst_n = 0, en_pwm = 0;
  logic [1:0] sel = 2'd3;
  logic supply_rise = 0, supply_low = 0, supply_high = 0;
  logic [N-1:0] led_short = '0, led_ok = '0;
  logic sw_ov = 0, dsc_oc = 0, dsc_drop = 0, comp_lock = 0, comp_gnd = 0;
  logic boost_en, ss_mode, comp_float, comp_dis, dsc_on, shdn_o;
  logic [N-1:0] sink_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  led_fault_seq #(.N_STR(N), .CLK_HZ(200_000), .DEGLITCH_US(50), .SHDN_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_pwm(en_pwm), .sel(sel),
    .supply_rise(supply_rise), .supply_low(supply_low), .supply_high(supply_high),
    .led_short(led_short), .led_ok(led_ok), .sw_ov(sw_ov), .dsc_oc(dsc_oc),
    .dsc_drop(dsc_drop), .comp_lock(comp_lock), .comp_gnd(comp_gnd),
    .boost_en(boost_en), .sink_en(sink_en), .ss_mode(ss_mode), .comp_float(comp_float),
    .comp_dis(comp_dis), .dsc_on(dsc_on), .shdn_o(shdn_o));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_shutdown_restart();
    en_pwm = 0; tick(LIM + 2);
    en_pwm = 1; led_ok = '1; tick(4);
  endtask

  task automatic t_reset();
    chk("R1 reset boost", boost_en, 0);
    chk("R1 reset sinks", sink_en, 0);
    chk("R9 reset dsc", dsc_on, 0);
    chk("R2 reset shdn", shdn_o, 0);
  endtask

  task automatic t_softstart();
    en_pwm = 1; tick(4);
    chk("R9 no supply_rise stays off", boost_en, 0);
    supply_rise = 1; tick(1); supply_rise = 0; tick(2);
    chk("R7 ss_mode on", ss_mode, 1);
    chk("R7 boost in ss", boost_en, 1);
    chk("R7 sinks in ss", sink_en, 4'hF);
    sel = 2'd1; led_ok = 4'b1101; tick(3);
    chk("R7 waits for selected string", ss_mode, 1);
    led_ok = 4'b0011; tick(1);
    chk("R7 unselected flags ignored, exits ss", ss_mode, 0);
    chk("R1 running boost", boost_en, 1);
    chk("R1 running sinks", sink_en, 4'b0011);
    led_ok = '1;
  endtask

  task automatic t_select();
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); tick(1);
      chk("R8 string mask", sink_en, (32'd1 << (s + 1)) - 1);
    end
  endtask

  task automatic t_pwm();
    en_pwm = 0; tick(2);
    chk("R1 pwm low boost off", boost_en, 0);
    chk("R1 pwm low sinks off", sink_en, 0);
    chk("R1 pwm low comp float", comp_float, 1);
    chk("R1 pwm low no shutdown", shdn_o, 0);
    en_pwm = 1; tick(2);
    chk("R12 direct run boost", boost_en, 1);
    chk("R12 no soft start", ss_mode, 0);
  endtask

  task automatic t_shutdown();
    en_pwm = 0; tick(LIM - 1);
    chk("R2 one short of limit", shdn_o, 0);
    tick(1);
    chk("R2 at limit", shdn_o, 1);
    tick(7);
    chk("R2 saturated", shdn_o, 1);
    led_ok = '0; en_pwm = 1; tick(1);
    chk("R2 cleared by enable", shdn_o, 0);
    tick(1);
    chk("R3 soft start after shutdown", ss_mode, 1);
    led_ok = '1; tick(2);
    chk("R3 run after shutdown", ss_mode, 0);
  endtask

  task automatic t_short();
    sel = 2'd0; led_short = 4'b1000; tick(1); led_short = '0;
    chk("R4 short on unselected pin boost", boost_en, 0);
    chk("R4 short sinks", sink_en, 0);
    en_pwm = 0; tick(5); en_pwm = 1; tick(5);
    chk("R4 held through pwm gap", boost_en, 0);
    do_shutdown_restart();
    chk("R3 short cleared boost", boost_en, 1);
    chk("R3 short cleared sinks", sink_en, 4'b0001);
    sel = 2'd3;
  endtask

  task automatic t_swov();
    sw_ov = 1; tick(1); sw_ov = 0;
    chk("R5 boost off", boost_en, 0);
    chk("R5 dsc off", dsc_on, 0);
    chk("R5 sinks off", sink_en, 0);
    tick(6);
    chk("R5 latched", dsc_on, 0);
    do_shutdown_restart();
    chk("R3 swov cleared dsc", dsc_on, 1);
    chk("R3 swov cleared boost", boost_en, 1);
  endtask

  task automatic t_oc();
    dsc_oc = 1; tick(1); dsc_oc = 0;
    chk("R6 dsc opens", dsc_on, 0);
    chk("R6 boost still on", boost_en, 1);
    dsc_drop = 1; tick(1); dsc_drop = 0;
    chk("R6 boost off on drop", boost_en, 0);
    chk("R6 sinks still on", sink_en, 4'hF);
    comp_lock = 1; tick(1); comp_lock = 0;
    chk("R6 sinks off at lockout", sink_en, 0);
    chk("R6 comp discharge", comp_dis, 1);
    comp_gnd = 1; tick(1); comp_gnd = 0;
    chk("R6 discharge ends", comp_dis, 0);
    chk("R6 soft start re-entered", ss_mode, 1);
    chk("R6 sinks back in ss", sink_en, 4'hF);
    tick(5);
    chk("R6 still soft start", ss_mode, 1);
    chk("R6 dsc stays open", dsc_on, 0);
    do_shutdown_restart();
    chk("R3 oc cleared dsc", dsc_on, 1);
    chk("R3 oc cleared ss", ss_mode, 0);
  endtask

  task automatic t_setdom();
    en_pwm = 0; tick(LIM + 2);
    chk("R2 in shutdown", shdn_o, 1);
    en_pwm = 1; led_short = 4'b0001; tick(1); led_short = '0;
    tick(4);
    chk("R11 short latched on shutdown edge", boost_en, 0);
    do_shutdown_restart();
    chk("R3 cleared after setdom", boost_en, 1);
  endtask

  task automatic t_uv();
    supply_low = 1; tick(DEG - 1); supply_low = 0; tick(2);
    chk("R9 short dip ignored", boost_en, 1);
    supply_low = 1; tick(DEG + 2);
    chk("R9 off after window", boost_en, 0);
    chk("R9 dsc off", dsc_on, 0);
    supply_low = 0; tick(5);
    chk("R9 waits for rise", boost_en, 0);
    supply_rise = 1; tick(1); supply_rise = 0; tick(4);
    chk("R9 back on", boost_en, 1);
  endtask

  task automatic t_ov();
    supply_high = 1; tick(DEG - 1); supply_high = 0; tick(2);
    chk("R10 short surge ignored", boost_en, 1);
    supply_high = 1; tick(DEG - 1);
    chk("R10 one before window", boost_en, 1);
    tick(1);
    chk("R10 boost stops at once", boost_en, 0);
    tick(3);
    chk("R10 device off", dsc_on, 0);
    led_ok = '0; supply_high = 0; tick(3);
    chk("R10 re-enters soft start", ss_mode, 1);
    led_ok = '1; tick(2);
    chk("R10 running again", boost_en, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1; tick(1);
    t_reset();
    t_softstart();
    t_select();
    t_pwm();
    t_shutdown();
    t_short();
    t_swov();
    t_oc();
    t_setdom();
    t_uv();
    t_ov();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule